// File: doc/BRIEF.md
# Automatic Memory-Range CRC Sequencer

This block computes a CRC-16 over a contiguous run of 512-byte memory sectors without processor help. Software programs a starting sector and a sector count, sets an enable bit, and then writes the trigger register. The engine fetches every byte of the range through a synchronous request/valid read port, one read in flight at a time, and folds each byte into a CRC-16 accumulator.

The range always covers count + 1 sectors. The final sector's base is (start + count) × 512, and the walk runs through that sector's last byte. A completion flag reads 0 for the whole run and returns to 1 once the final byte has been absorbed. The 16-bit result can then be read as two byte registers. While a run is active, the configuration is frozen and further trigger writes are ignored.

Top module: `crc_range_seq`

## Requirements
- R1: After reset, the auto-control register (address 0) reads 0x40, the count register (address 1) reads 0x00, both result bytes (addresses 3 and 4) read 0xFF, and mem_req_o is 0.
- R2: In the auto-control register, bit 7 is enable and bit 6 is the read-only completion flag. Bit 5 always reads 0. Bits 4:0 hold the start sector. In the count register, bits 5:0 hold the count, and bits 7:6 read 0 whatever is written to them.
- R3: A write to the trigger register (address 2) starts a run only when enable is 1. With enable at 0, the write issues no memory request and the completion flag stays 1.
- R4: The first byte address requested in a run is start × 512.
- R5: Byte addresses rise by one after each accepted byte. The last address is (start + count) × 512 + 511, so exactly (count + 1) × 512 bytes are read.
- R6: Only one read is outstanding at a time. While mem_req_o is high and mem_valid_i is low, mem_addr_o holds its value.
- R7: The completion flag reads 0 from the cycle after the trigger write until the final byte is accepted, and then returns to 1. The run never ends without a valid byte. mem_req_o is low whenever the flag is 1.
- R8: The result is CRC-16 with polynomial 0x1021, seed 0xFFFF, processed MSB-first per byte. Address 3 returns the low byte and address 4 returns the high byte.
- R9: During a run, writes to the auto-control and count registers are ignored, and a further trigger write does not restart the walk.
- R10: If (start + count) lies beyond the last addressable sector, the end address clamps to the all-ones address. The run still completes and sets the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select (0 auto-control, 1 count, 2 trigger, 3 result low, 4 result high) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Read request, held until a byte is returned |
| mem_addr_o | output | ADDR_W | Byte address of the pending read |
| mem_valid_i | input | 1 | Read data valid; the byte is accepted on this cycle |
| mem_rdata_i | input | 8 | Read data byte |

## Verification
Every cycle, the assertions check the memory-port discipline: the address is held while a read is pending, it steps by exactly one after each accepted byte, and it starts at start × 512. They also check that no run begins with enable clear and that the configuration stays frozen during a run. Only the bench's scenarios can show that the CRC value is correct, that the byte count and end address match count + 1 sectors (including count = 0), and that the completion flag is visible through the register interface. The same holds for clamping in a narrow-address instance and for the lockout of mid-run writes, which is observed through register readback.

// File: rtl/crc_seq_pkg.sv
package crc_seq_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    REG_AUTO   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_RES_LO = 3'd3,
    REG_RES_HI = 3'd4
  } reg_sel_e;

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/crc_seq_regs.sv
module crc_seq_regs
  import crc_seq_pkg::*;
#(
  parameter int START_W = 5,
  parameter int COUNT_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               busy_i,
  input  logic [15:0]        crc_i,
  output logic [7:0]         rdata_o,
  output logic               en_o,
  output logic [START_W-1:0] start_o,
  output logic [COUNT_W-1:0] count_o,
  output logic               trig_o
);
  logic               en_q;
  logic [START_W-1:0] start_q;
  logic [COUNT_W-1:0] count_q;

  // configuration is frozen while a run is active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      start_q <= '0;
      count_q <= '0;
    end else if (we_i && !busy_i) begin
      if (addr_i == REG_AUTO) begin
        en_q    <= wdata_i[7];
        start_q <= wdata_i[START_W-1:0];
      end
      if (addr_i == REG_COUNT) count_q <= wdata_i[COUNT_W-1:0];
    end
  end

  assign trig_o = we_i && (addr_i == REG_CTRL) && en_q && !busy_i;

  always_comb begin
    case (addr_i)
      REG_AUTO:   rdata_o = {en_q, ~busy_i, 1'b0, 5'(start_q)};
      REG_COUNT:  rdata_o = 8'(count_q);
      REG_RES_LO: rdata_o = crc_i[7:0];
      REG_RES_HI: rdata_o = crc_i[15:8];
      default:    rdata_o = 8'h00;
    endcase
  end

  assign en_o    = en_q;
  assign start_o = start_q;
  assign count_o = count_q;
endmodule

// File: rtl/crc_seq_addr.sv
module crc_seq_addr #(
  parameter int ADDR_W  = 16,
  parameter int SECT_W  = 9,
  parameter int START_W = 5,
  parameter int COUNT_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [START_W-1:0] start_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               step_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               last_o
);
  localparam int SUM_W     = ((START_W > COUNT_W) ? START_W : COUNT_W) + 1;
  localparam int SEC_IDX_W = ADDR_W - SECT_W;
  localparam int LAST_SEC  = (2 ** SEC_IDX_W) - 1;

  logic [SUM_W-1:0]  sum;
  logic [ADDR_W-1:0] first_addr, end_addr, cur_q, end_q;

  assign sum        = SUM_W'(start_i) + SUM_W'(count_i);
  assign first_addr = ADDR_W'({start_i, {SECT_W{1'b0}}});
  // clamp to the top of the address space when the last sector falls off the end
  assign end_addr   = (32'(sum) > 32'(LAST_SEC)) ? {ADDR_W{1'b1}}
                                                 : {SEC_IDX_W'(sum), {SECT_W{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      end_q <= '0;
    end else if (load_i) begin
      cur_q <= first_addr;
      end_q <= end_addr;
    end else if (step_i) begin
      cur_q <= cur_q + 1'b1;
    end
  end

  assign addr_o = cur_q;
  assign last_o = (cur_q == end_q);
endmodule

// File: rtl/crc_seq_acc.sv
module crc_seq_acc
  import crc_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (init_i) crc_q <= CRC_SEED;
    else if (upd_i)  crc_q <= crc_byte(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/crc_range_seq.sv
module crc_range_seq
  import crc_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SECT_W  = 9,
  parameter int START_W = 5,
  parameter int COUNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_rdata_i
);
  logic               busy_q, trig, last, take;
  logic               en_q;
  logic [START_W-1:0] start_q;
  logic [COUNT_W-1:0] count_q;
  logic [15:0]        crc;

  assign take = busy_q && mem_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            busy_q <= 1'b0;
    else if (trig)          busy_q <= 1'b1;
    else if (take && last)  busy_q <= 1'b0;
  end

  crc_seq_regs #(.START_W(START_W), .COUNT_W(COUNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_q), .crc_i(crc), .rdata_o(reg_rdata_o),
    .en_o(en_q), .start_o(start_q), .count_o(count_q), .trig_o(trig)
  );

  crc_seq_addr #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .START_W(START_W), .COUNT_W(COUNT_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(trig), .start_i(start_q), .count_i(count_q),
    .step_i(take && !last), .addr_o(mem_addr_o), .last_o(last)
  );

  crc_seq_acc u_acc (
    .clk_i, .rst_ni,
    .init_i(trig), .upd_i(take), .data_i(mem_rdata_i), .crc_o(crc)
  );

  assign mem_req_o = busy_q;
endmodule

// File: rtl/crc_range_seq_chk.sv
module crc_range_seq_chk #(
  parameter int ADDR_W  = 16,
  parameter int SECT_W  = 9,
  parameter int START_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mem_req_o,
  input logic               mem_valid_i,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               en_q,
  input logic [START_W-1:0] start_q
);
  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> $stable(mem_addr_o));
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> mem_req_o);
  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + 1'b1)));
  // R4
  first_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o == ADDR_W'({start_q, {SECT_W{1'b0}}})));
  // R3
  no_start_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && !en_q) |=> !mem_req_o);
  // R9
  cfg_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o || ($stable(start_q) && $stable(en_q))));
endmodule

bind crc_range_seq crc_range_seq_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .START_W(START_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_valid_i(mem_valid_i),
  .mem_addr_o(mem_addr_o), .en_q(en_q), .start_q(start_q)
);

// File: tb/tb_crc_range_seq.sv
module tb_crc_range_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata, rdata_c;
  logic        req, req_c, valid = 1'b0, valid_c = 1'b0;
  logic [15:0] maddr;
  logic [13:0] maddr_c;
  logic [7:0]  mdata = 8'h00, mdata_c = 8'h00;
  int n_chk = 0, n_err = 0;
  int n_bytes = 0, n_bytes_c = 0, n_rise = 0;
  int first_a = 0, last_a = 0, last_c = 0;
  logic req_d = 1'b0;

  always #4 clk = ~clk;

  crc_range_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_req_o(req), .mem_addr_o(maddr), .mem_valid_i(valid), .mem_rdata_i(mdata)
  );
  // narrow address space for the clamp case
  crc_range_seq #(.ADDR_W(14)) dut_c (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_c), .mem_req_o(req_c), .mem_addr_o(maddr_c), .mem_valid_i(valid_c),
    .mem_rdata_i(mdata_c)
  );

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] sw_crc(int lo, int hi);
    logic [15:0] c = 16'hFFFF;
    for (int a = lo; a <= hi; a++) begin
      logic [7:0] d = mem_byte(16'(a));
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ d[b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  // memory models: one-cycle latency, valid pulses every other cycle
  always @(posedge clk) begin
    valid   <= rst_n && req && !valid;
    mdata   <= mem_byte(maddr);
    valid_c <= rst_n && req_c && !valid_c;
    mdata_c <= mem_byte({2'b00, maddr_c});
    req_d   <= req;
    if (req && !req_d) begin first_a <= int'(maddr); n_rise <= n_rise + 1; end
    if (req && valid) begin n_bytes <= n_bytes + 1; last_a <= int'(maddr); end
    if (req_c && valid_c) begin n_bytes_c <= n_bytes_c + 1; last_c <= int'(maddr_c); end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d, output logic [7:0] dc);
    @(negedge clk); addr = a; #1; d = rdata; dc = rdata_c;
  endtask

  task automatic wait_done();
    logic [7:0] d, dc;
    do rd(3'd0, d, dc); while (!(d[6] && dc[6]));
  endtask

  task automatic check_crc(string tag, int lo, int hi);
    logic [7:0] l, h, lc, hc;
    logic [15:0] e = sw_crc(lo, hi);
    rd(3'd3, l, lc); rd(3'd4, h, hc);
    check({tag, " crc lo"}, int'(l), int'(e[7:0]));
    check({tag, " crc hi"}, int'(h), int'(e[15:8]));
  endtask

  // {start[4:0], count[5:0], expected bytes[15:0]}
  localparam logic [26:0] VEC [5] = '{
    {5'd0,  6'd0, 16'd512},
    {5'd3,  6'd1, 16'd1024},
    {5'd31, 6'd0, 16'd512},
    {5'd7,  6'd2, 16'd1536},
    {5'd1,  6'd3, 16'd2048}
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, dc;
    int b0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d, dc); check("R1 auto", int'(d), 'h40);
    rd(3'd1, d, dc); check("R1 count", int'(d), 'h00);
    rd(3'd3, d, dc); check("R1 res lo", int'(d), 'hFF);
    rd(3'd4, d, dc); check("R1 res hi", int'(d), 'hFF);
    check("R1 req", int'(req), 0);

    // R2 reserved and unused bits
    wr(3'd0, 8'h3F); rd(3'd0, d, dc); check("R2 auto", int'(d), 'h5F);
    wr(3'd1, 8'hFF); rd(3'd1, d, dc); check("R2 count", int'(d), 'h3F);

    // R3 trigger with enable clear
    r0 = n_rise;
    wr(3'd2, 8'h00);
    repeat (20) @(negedge clk);
    check("R3 no run", n_rise - r0, 0);
    rd(3'd0, d, dc); check("R3 done", int'(d[6]), 1);

    // R4 R5 R7 R8 vector table
    foreach (VEC[i]) begin
      int st  = int'(VEC[i][26:22]);
      int cnt = int'(VEC[i][21:16]);
      int nb  = int'(VEC[i][15:0]);
      wr(3'd0, 8'h80 | 8'(st));
      wr(3'd1, 8'(cnt));
      b0 = n_bytes;
      wr(3'd2, 8'h00);
      rd(3'd0, d, dc); check("R7 busy", int'(d[6]), 0);
      wait_done();
      check("R7 req low", int'(req), 0);
      check("R4 first", first_a, st * 512);
      check("R5 bytes", n_bytes - b0, nb);
      check("R5 last", last_a, (st + cnt) * 512 + 511);
      check_crc("R8", st * 512, (st + cnt) * 512 + 511);
    end

    // R9 writes during a run are ignored
    wr(3'd0, 8'h82); wr(3'd1, 8'h00);
    b0 = n_bytes;
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h1F); wr(3'd1, 8'h3F); wr(3'd2, 8'h00);
    wait_done();
    rd(3'd0, d, dc); check("R9 auto", int'(d), 'hC2);
    rd(3'd1, d, dc); check("R9 count", int'(d), 'h00);
    check("R9 bytes", n_bytes - b0, 512);
    check_crc("R9", 1024, 1535);

    // R10 clamp in the 14-bit instance; 16-bit instance runs the full range
    wr(3'd0, 8'h9E); wr(3'd1, 8'h05);
    b0 = n_bytes; r0 = n_bytes_c;
    wr(3'd2, 8'h00);
    wait_done();
    check("R10 full bytes", n_bytes - b0, 3072);
    check("R10 full last", last_a, 18431);
    check("R10 clamp bytes", n_bytes_c - r0, 1024);
    check("R10 clamp last", last_c, 16383);
    rd(3'd0, d, dc); check("R10 clamp done", int'(dc[6]), 1);
    begin
      logic [7:0] l, h, lc, hc;
      logic [15:0] e = sw_crc(30 * 512, 16383);
      rd(3'd3, l, lc); rd(3'd4, h, hc);
      check("R10 clamp crc", int'({hc, lc}), int'(e));
    end

    summary();
    $finish;
  end
endmodule